// File: doc/BRIEF.md
# Integer and Memory-Access Instruction Decoder

This block turns one 32-bit fixed-width instruction word into the control fields that an integer pipeline needs. It recognises register-register and register-immediate add, and, or and compare operations, as well as byte, halfword and word loads and stores in displacement, displacement-with-update and register-indexed forms. For each word it reports an internal operation code, which register indices go to three read ports and one write port, a decoded 32-bit immediate, the record flag, the access width and the update flag.

A single control input reverses the four bytes of the incoming word before decoding. This lets the same block serve fetch paths of either memory byte order. The decode logic itself is combinational. The result is captured in one output register stage, so results appear one clock after the word is presented. Any encoding outside the supported set decodes as an illegal operation with every enable low.

Fields use big-endian bit numbering, where bit 0 is the word's MSB:
- primary opcode: bits 0–5, i.e. word[31:26]
- RT/RS: bits 6–10, i.e. word[25:21]
- RA: bits 11–15, i.e. word[20:16]
- RB: bits 16–20, i.e. word[15:11]
- extended opcode: bits 21–30, i.e. word[10:1]
- record bit: bit 31, i.e. word[0]
- 16-bit immediate: word[15:0]

Top module: `intop_decoder`

## Requirements
- R1: While `rst` is high at a rising edge, every output is cleared to 0 on that edge, which means op code 0 with all enables low.
- R2: Outputs are registered, so a word's decode appears after the first rising edge that samples it and not before. The op codes are 0 illegal, 1 add, 2 and, 3 or, 4 load, 5 store and 6 compare.
- R3: With `swap_i` = 0 the word is decoded as given. With `swap_i` = 1 its bytes are reversed first, so byte 0 becomes byte 3, and the decode equals that of the reversed word.
- R4: Add and load routing works as follows.
  - Add-immediate (primary 14) and add-immediate-high (15) put RA on read port 1 and RT on the write port.
  - Loads put RA on read port 1 and RT on the write port. The loads are displacement word (32), word with update (33), byte (34) and halfword (40), plus indexed word (primary 31, extended 23).
  - Register add (primary 31, extended 266) drives read port 1 from RA, read port 2 from RB and the write port from RT.
  - The indexed load also drives read port 2 from RB.
- R5: Logical operations write the RA field. They put the RS field (bits 6–10) on read port 3 and leave read port 1 disabled. The logical operations are or-immediate (24), and-immediate-record (28), register and (31/28) and register or (31/444). The register forms also drive read port 2 from RB.
- R6: Immediate decoding depends on the form.
  - Add-immediate and all displacement loads/stores sign-extend the 16-bit immediate.
  - Or/and-immediate zero-extend it.
  - Add-immediate-high places it in bits 31:16 with zeros below.
  - Register forms leave the immediate output 0 with its enable low.
- R7: Stores put RA on read port 1 and RS on read port 3, and assert no write enable. The stores are displacement word (36), word with update (37), byte (38) and halfword (44), plus indexed word (31/151). The indexed store also drives read port 2 from RB.
- R8: The access width output is 4 for word, 2 for halfword and 1 for byte accesses, and 0 for every non-memory operation.
- R9: The update output is 1 only for the two update forms (33 and 37) and 0 for everything else.
- R10: The record output follows word bit 31 for register add/and/or. It is always 1 for and-immediate-record and always 0 for every other operation, whatever bit 31 holds.
- R11: Register compare (31/0) puts RA on read port 1 and RB on read port 2. It emits word bits 6–8 as a 3-bit condition field index and has no write. The field index is 0 for every other operation.
- R12: Any other primary opcode, or primary 31 with any other extended opcode, yields op code 0. For such words every enable is low and every selector, the immediate, record, width, update and field outputs are 0. For all words, a selector whose enable is low reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| insn_i | input | 32 | Raw instruction word |
| swap_i | input | 1 | 1 reverses the word's bytes before decoding |
| op_o | output | 3 | Internal operation code |
| rd1_en_o | output | 1 | Read port 1 used |
| rd1_o | output | 5 | Read port 1 register index |
| rd2_en_o | output | 1 | Read port 2 used |
| rd2_o | output | 5 | Read port 2 register index |
| rd3_en_o | output | 1 | Read port 3 used |
| rd3_o | output | 5 | Read port 3 register index |
| wr_en_o | output | 1 | Write port used |
| wr_o | output | 5 | Write register index |
| imm_en_o | output | 1 | Immediate valid |
| imm_o | output | 32 | Decoded immediate |
| rc_o | output | 1 | Record flag |
| len_o | output | 3 | Access width in bytes |
| upd_o | output | 1 | Update form |
| crf_o | output | 3 | Condition field index for compare |

## Verification
The hardest situations to reach are words that carry a valid primary opcode 31 but an extended opcode just beside a supported one. A directed test would rarely hit the few encodings that differ from a legal code by one bit. The bench therefore sweeps all 1024 extended values under primary 31 and all 64 primary values, with every non-opcode field set to ones. It feeds the extended sweep through the byte-reversal path, so that a fault in the byte permutation shows up together with any false match. Every supported form is applied with boundary immediates (0x7FFF, 0x8000, 0xFFFF, 0) and with bit 31 toggled. This exposes sign-extension faults and any record flag that leaks into forms that must ignore it.

// File: rtl/idec_pkg.sv
package idec_pkg;
  localparam int XLEN = 32;
  localparam int RIDX = 5;
  localparam int POW  = 6;
  localparam int XOW  = 10;
  localparam int LENW = 3;
  localparam int CRFW = 3;

  typedef enum logic [2:0] {
    OP_ILL   = 3'd0,
    OP_ADD   = 3'd1,
    OP_AND   = 3'd2,
    OP_OR    = 3'd3,
    OP_LOAD  = 3'd4,
    OP_STORE = 3'd5,
    OP_CMP   = 3'd6
  } iop_e;

  typedef enum logic [1:0] {
    IMM_NONE = 2'd0,
    IMM_SEXT = 2'd1,
    IMM_ZEXT = 2'd2,
    IMM_HIGH = 2'd3
  } imm_kind_e;

  // primary opcodes
  localparam logic [POW-1:0] PO_ADD_IMM    = 6'd14;
  localparam logic [POW-1:0] PO_ADD_IMM_HI = 6'd15;
  localparam logic [POW-1:0] PO_OR_IMM     = 6'd24;
  localparam logic [POW-1:0] PO_AND_IMM_RC = 6'd28;
  localparam logic [POW-1:0] PO_EXT        = 6'd31;
  localparam logic [POW-1:0] PO_LD_W       = 6'd32;
  localparam logic [POW-1:0] PO_LD_WU      = 6'd33;
  localparam logic [POW-1:0] PO_LD_B       = 6'd34;
  localparam logic [POW-1:0] PO_ST_W       = 6'd36;
  localparam logic [POW-1:0] PO_ST_WU      = 6'd37;
  localparam logic [POW-1:0] PO_ST_B       = 6'd38;
  localparam logic [POW-1:0] PO_LD_H       = 6'd40;
  localparam logic [POW-1:0] PO_ST_H       = 6'd44;
  // extended opcodes under PO_EXT
  localparam logic [XOW-1:0] XO_CMP   = 10'd0;
  localparam logic [XOW-1:0] XO_LD_WX = 10'd23;
  localparam logic [XOW-1:0] XO_AND   = 10'd28;
  localparam logic [XOW-1:0] XO_ST_WX = 10'd151;
  localparam logic [XOW-1:0] XO_ADD   = 10'd266;
  localparam logic [XOW-1:0] XO_OR    = 10'd444;

  typedef struct packed {
    iop_e            op;
    logic            use_ra;
    logic            use_rb;
    logic            src_rs;
    logic            wr_rt;
    logic            wr_ra;
    imm_kind_e       imm;
    logic            rc_from_bit;
    logic            rc_force;
    logic [LENW-1:0] len;
    logic            upd;
    logic            crf;
  } ctl_t;

  typedef struct packed {
    iop_e            op;
    logic            rd1_en;
    logic [RIDX-1:0] rd1;
    logic            rd2_en;
    logic [RIDX-1:0] rd2;
    logic            rd3_en;
    logic [RIDX-1:0] rd3;
    logic            wr_en;
    logic [RIDX-1:0] wr;
    logic            imm_en;
    logic [XLEN-1:0] imm;
    logic            rc;
    logic [LENW-1:0] len;
    logic            upd;
    logic [CRFW-1:0] crf;
  } dec_t;
endpackage

// File: rtl/idec_swap.sv
module idec_swap #(
  parameter int IW = 32
) (
  input  logic          swap,
  input  logic [IW-1:0] raw,
  output logic [IW-1:0] word
);
  localparam int NB = IW / 8;
  logic [IW-1:0] rev;

  for (genvar g = 0; g < NB; g++) begin : g_byte
    assign rev[g*8 +: 8] = raw[(NB-1-g)*8 +: 8];
  end

  assign word = swap ? rev : raw;
endmodule

// File: rtl/idec_class.sv
module idec_class
  import idec_pkg::*;
(
  input  logic [POW-1:0] pri,
  input  logic [XOW-1:0] xo,
  output ctl_t           ctl
);
  always_comb begin
    ctl = '0;
    unique case (pri)
      PO_ADD_IMM, PO_ADD_IMM_HI: begin
        ctl.op     = OP_ADD;
        ctl.use_ra = 1'b1;
        ctl.wr_rt  = 1'b1;
        ctl.imm    = (pri == PO_ADD_IMM_HI) ? IMM_HIGH : IMM_SEXT;
      end
      PO_OR_IMM, PO_AND_IMM_RC: begin
        ctl.op       = (pri == PO_OR_IMM) ? OP_OR : OP_AND;
        ctl.src_rs   = 1'b1;
        ctl.wr_ra    = 1'b1;
        ctl.imm      = IMM_ZEXT;
        ctl.rc_force = (pri == PO_AND_IMM_RC);
      end
      PO_LD_W, PO_LD_WU, PO_LD_B, PO_LD_H: begin
        ctl.op     = OP_LOAD;
        ctl.use_ra = 1'b1;
        ctl.wr_rt  = 1'b1;
        ctl.imm    = IMM_SEXT;
        ctl.len    = (pri == PO_LD_B) ? 3'd1 : (pri == PO_LD_H) ? 3'd2 : 3'd4;
        ctl.upd    = (pri == PO_LD_WU);
      end
      PO_ST_W, PO_ST_WU, PO_ST_B, PO_ST_H: begin
        ctl.op     = OP_STORE;
        ctl.use_ra = 1'b1;
        ctl.src_rs = 1'b1;
        ctl.imm    = IMM_SEXT;
        ctl.len    = (pri == PO_ST_B) ? 3'd1 : (pri == PO_ST_H) ? 3'd2 : 3'd4;
        ctl.upd    = (pri == PO_ST_WU);
      end
      PO_EXT: begin
        unique case (xo)
          XO_CMP: begin
            ctl.op     = OP_CMP;
            ctl.use_ra = 1'b1;
            ctl.use_rb = 1'b1;
            ctl.crf    = 1'b1;
          end
          XO_LD_WX: begin
            ctl.op     = OP_LOAD;
            ctl.use_ra = 1'b1;
            ctl.use_rb = 1'b1;
            ctl.wr_rt  = 1'b1;
            ctl.len    = 3'd4;
          end
          XO_ST_WX: begin
            ctl.op     = OP_STORE;
            ctl.use_ra = 1'b1;
            ctl.use_rb = 1'b1;
            ctl.src_rs = 1'b1;
            ctl.len    = 3'd4;
          end
          XO_ADD: begin
            ctl.op          = OP_ADD;
            ctl.use_ra      = 1'b1;
            ctl.use_rb      = 1'b1;
            ctl.wr_rt       = 1'b1;
            ctl.rc_from_bit = 1'b1;
          end
          XO_AND, XO_OR: begin
            ctl.op          = (xo == XO_AND) ? OP_AND : OP_OR;
            ctl.use_rb      = 1'b1;
            ctl.src_rs      = 1'b1;
            ctl.wr_ra       = 1'b1;
            ctl.rc_from_bit = 1'b1;
          end
          default: ctl = '0;
        endcase
      end
      default: ctl = '0;
    endcase
  end
endmodule

// File: rtl/idec_route.sv
module idec_route
  import idec_pkg::*;
#(
  parameter int IW = XLEN,
  parameter int RW = RIDX
) (
  input  ctl_t             ctl,
  input  logic [RW-1:0]    f_rt,
  input  logic [RW-1:0]    f_ra,
  input  logic [RW-1:0]    f_rb,
  input  logic [IW/2-1:0]  f_imm,
  input  logic             f_rc,
  output dec_t             dec
);
  localparam int HW = IW / 2;

  always_comb begin
    dec    = '0;
    dec.op = ctl.op;
    if (ctl.use_ra) begin
      dec.rd1_en = 1'b1;
      dec.rd1    = f_ra;
    end
    if (ctl.use_rb) begin
      dec.rd2_en = 1'b1;
      dec.rd2    = f_rb;
    end
    if (ctl.src_rs) begin
      dec.rd3_en = 1'b1;
      dec.rd3    = f_rt;
    end
    if (ctl.wr_rt) begin
      dec.wr_en = 1'b1;
      dec.wr    = f_rt;
    end else if (ctl.wr_ra) begin
      dec.wr_en = 1'b1;
      dec.wr    = f_ra;
    end
    unique case (ctl.imm)
      IMM_SEXT: begin dec.imm_en = 1'b1; dec.imm = {{(IW-HW){f_imm[HW-1]}}, f_imm}; end
      IMM_ZEXT: begin dec.imm_en = 1'b1; dec.imm = {{(IW-HW){1'b0}}, f_imm}; end
      IMM_HIGH: begin dec.imm_en = 1'b1; dec.imm = {f_imm, {(IW-HW){1'b0}}}; end
      default:  begin dec.imm_en = 1'b0; dec.imm = '0; end
    endcase
    dec.rc  = ctl.rc_force | (ctl.rc_from_bit & f_rc);
    dec.len = ctl.len;
    dec.upd = ctl.upd;
    if (ctl.crf) dec.crf = f_rt[RW-1 -: CRFW];
  end
endmodule

// File: rtl/intop_decoder.sv
module intop_decoder
  import idec_pkg::*;
#(
  parameter int IW = XLEN,
  parameter int RW = RIDX
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [IW-1:0]   insn_i,
  input  logic            swap_i,
  output logic [2:0]      op_o,
  output logic            rd1_en_o,
  output logic [RW-1:0]   rd1_o,
  output logic            rd2_en_o,
  output logic [RW-1:0]   rd2_o,
  output logic            rd3_en_o,
  output logic [RW-1:0]   rd3_o,
  output logic            wr_en_o,
  output logic [RW-1:0]   wr_o,
  output logic            imm_en_o,
  output logic [IW-1:0]   imm_o,
  output logic            rc_o,
  output logic [LENW-1:0] len_o,
  output logic            upd_o,
  output logic [CRFW-1:0] crf_o
);
  localparam int PO_LSB = IW - POW;       // bits 0..5
  localparam int RT_LSB = PO_LSB - RW;    // bits 6..10
  localparam int RA_LSB = RT_LSB - RW;    // bits 11..15
  localparam int RB_LSB = RA_LSB - RW;    // bits 16..20
  localparam int HW     = IW / 2;

  logic [IW-1:0] word;
  ctl_t          ctl;
  dec_t          dec_d, dec_q;

  idec_swap #(.IW(IW)) u_swap (
    .swap (swap_i),
    .raw  (insn_i),
    .word (word)
  );

  idec_class u_class (
    .pri (word[PO_LSB +: POW]),
    .xo  (word[1 +: XOW]),
    .ctl (ctl)
  );

  idec_route #(.IW(IW), .RW(RW)) u_route (
    .ctl   (ctl),
    .f_rt  (word[RT_LSB +: RW]),
    .f_ra  (word[RA_LSB +: RW]),
    .f_rb  (word[RB_LSB +: RW]),
    .f_imm (word[HW-1:0]),
    .f_rc  (word[0]),
    .dec   (dec_d)
  );

  always_ff @(posedge clk) begin
    if (rst) dec_q <= '0;
    else     dec_q <= dec_d;
  end

  assign op_o     = dec_q.op;
  assign rd1_en_o = dec_q.rd1_en;
  assign rd1_o    = dec_q.rd1;
  assign rd2_en_o = dec_q.rd2_en;
  assign rd2_o    = dec_q.rd2;
  assign rd3_en_o = dec_q.rd3_en;
  assign rd3_o    = dec_q.rd3;
  assign wr_en_o  = dec_q.wr_en;
  assign wr_o     = dec_q.wr;
  assign imm_en_o = dec_q.imm_en;
  assign imm_o    = dec_q.imm;
  assign rc_o     = dec_q.rc;
  assign len_o    = dec_q.len;
  assign upd_o    = dec_q.upd;
  assign crf_o    = dec_q.crf;

  AST_ILL_QUIET: assert property (@(posedge clk) disable iff (rst)
    (op_o == OP_ILL) |-> !(rd1_en_o || rd2_en_o || rd3_en_o || wr_en_o || imm_en_o || rc_o || upd_o)); // R12
  AST_STORE_NOWR: assert property (@(posedge clk) disable iff (rst)
    (op_o == OP_STORE) |-> (!wr_en_o && rd3_en_o && rd1_en_o)); // R7
  AST_LEN_SCOPE: assert property (@(posedge clk) disable iff (rst)
    ((op_o == OP_LOAD) || (op_o == OP_STORE)) == ($countones(len_o) == 1)); // R8
  AST_UPD_MEM: assert property (@(posedge clk) disable iff (rst)
    upd_o |-> (((op_o == OP_LOAD) || (op_o == OP_STORE)) && imm_en_o && len_o == 3'd4)); // R9
  AST_RC_SCOPE: assert property (@(posedge clk) disable iff (rst)
    rc_o |-> ((op_o == OP_ADD) || (op_o == OP_AND) || (op_o == OP_OR))); // R10
  AST_CMP_NOWR: assert property (@(posedge clk) disable iff (rst)
    (op_o == OP_CMP) |-> (!wr_en_o && rd1_en_o && rd2_en_o && !imm_en_o)); // R11
  AST_RESET_CLEAR: assert property (@(posedge clk)
    $past(rst) |-> (op_o == OP_ILL && !wr_en_o && imm_o == '0)); // R1
endmodule

// File: tb/intop_decoder_tb.sv
`timescale 1ns/1ps
module intop_decoder_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] insn = '0;
  logic        swap = 1'b0;

  logic [2:0]  op_o, len_o, crf_o;
  logic        rd1_en_o, rd2_en_o, rd3_en_o, wr_en_o, imm_en_o, rc_o, upd_o;
  logic [4:0]  rd1_o, rd2_o, rd3_o, wr_o;
  logic [31:0] imm_o;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  intop_decoder u_dut (
    .clk(clk), .rst(rst), .insn_i(insn), .swap_i(swap),
    .op_o(op_o), .rd1_en_o(rd1_en_o), .rd1_o(rd1_o), .rd2_en_o(rd2_en_o), .rd2_o(rd2_o),
    .rd3_en_o(rd3_en_o), .rd3_o(rd3_o), .wr_en_o(wr_en_o), .wr_o(wr_o),
    .imm_en_o(imm_en_o), .imm_o(imm_o), .rc_o(rc_o), .len_o(len_o), .upd_o(upd_o), .crf_o(crf_o)
  );

  // {op, ports(24), imm_en+imm(33), rc, len, upd, crf} = 68 bits
  logic [67:0] act_v;
  assign act_v = {op_o, rd1_en_o, rd1_o, rd2_en_o, rd2_o, rd3_en_o, rd3_o, wr_en_o, wr_o,
                  imm_en_o, imm_o, rc_o, len_o, upd_o, crf_o};

  task automatic chk(input string tag, input logic [67:0] a, input logic [67:0] e);
    checks++;
    if (a !== e) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, a, e);
    end
  endtask

  function automatic logic [31:0] bswap(input logic [31:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction

  // kinds: 0 addi 1 addis 2 ori 3 andi. 4 lwz 5 lwzu 6 lbz 7 lhz 8 stw 9 stwu 10 stb 11 sth
  //        12 cmp 13 lwzx 14 and 15 stwx 16 add 17 or
  function automatic logic [5:0] pri_of(input int k);
    case (k)
      0: return 6'd14;  1: return 6'd15;  2: return 6'd24;  3: return 6'd28;
      4: return 6'd32;  5: return 6'd33;  6: return 6'd34;  7: return 6'd40;
      8: return 6'd36;  9: return 6'd37;  10: return 6'd38; 11: return 6'd44;
      default: return 6'd31;
    endcase
  endfunction

  function automatic logic [9:0] xo_of(input int k);
    case (k)
      12: return 10'd0;   13: return 10'd23;  14: return 10'd28;
      15: return 10'd151; 16: return 10'd266; default: return 10'd444;
    endcase
  endfunction

  task automatic apply(input logic [31:0] w, input logic s);
    @(negedge clk);
    insn = s ? bswap(w) : w;
    swap = s;
    @(posedge clk);
    #1;
  endtask

  task automatic run_kind(input int k, input logic [4:0] rt, input logic [4:0] ra, input logic [4:0] rb,
                          input logic [15:0] i16, input logic rcb, input logic s);
    logic [31:0] w;
    logic [2:0]  e_op, e_len, e_crf;
    logic        e1, e2, e3, ew, ei, erc, eu;
    logic [4:0]  r1, r2, r3, rw;
    logic [31:0] eimm;
    logic [67:0] ev;
    string pt, pre;
    e_op = 0; e_len = 0; e_crf = 0; e1 = 0; e2 = 0; e3 = 0; ew = 0; ei = 0; erc = 0; eu = 0;
    r1 = 0; r2 = 0; r3 = 0; rw = 0; eimm = 0; pt = "R4";
    if (k < 12) w = {pri_of(k), rt, ra, i16};
    else        w = {6'd31, rt, ra, rb, xo_of(k), rcb};
    case (k)
      0, 1: begin e_op = 1; e1 = 1; r1 = ra; ew = 1; rw = rt; ei = 1;
              eimm = (k == 1) ? {i16, 16'h0} : {{16{i16[15]}}, i16}; end
      2, 3: begin e_op = (k == 2) ? 3 : 2; e3 = 1; r3 = rt; ew = 1; rw = ra; ei = 1;
              eimm = {16'h0, i16}; erc = (k == 3); pt = "R5"; end
      4, 5, 6, 7: begin e_op = 4; e1 = 1; r1 = ra; ew = 1; rw = rt; ei = 1;
              eimm = {{16{i16[15]}}, i16}; eu = (k == 5);
              e_len = (k == 6) ? 1 : (k == 7) ? 2 : 4; end
      8, 9, 10, 11: begin e_op = 5; e1 = 1; r1 = ra; e3 = 1; r3 = rt; ei = 1;
              eimm = {{16{i16[15]}}, i16}; eu = (k == 9);
              e_len = (k == 10) ? 1 : (k == 11) ? 2 : 4; pt = "R7"; end
      12: begin e_op = 6; e1 = 1; r1 = ra; e2 = 1; r2 = rb; e_crf = rt[4:2]; pt = "R11"; end
      13: begin e_op = 4; e1 = 1; r1 = ra; e2 = 1; r2 = rb; ew = 1; rw = rt; e_len = 4; end
      15: begin e_op = 5; e1 = 1; r1 = ra; e2 = 1; r2 = rb; e3 = 1; r3 = rt; e_len = 4; pt = "R7"; end
      16: begin e_op = 1; e1 = 1; r1 = ra; e2 = 1; r2 = rb; ew = 1; rw = rt; erc = rcb; end
      default: begin e_op = (k == 14) ? 2 : 3; e2 = 1; r2 = rb; e3 = 1; r3 = rt; ew = 1; rw = ra;
              erc = rcb; pt = "R5"; end
    endcase
    ev = {e_op, e1, r1, e2, r2, e3, r3, ew, rw, ei, eimm, erc, e_len, eu, e_crf};
    pre = s ? "R3 " : "";
    apply(w, s);
    chk({pre, "R2 op"},           {65'h0, act_v[67:65]}, {65'h0, ev[67:65]});
    chk({pre, pt, " ports"},      {44'h0, act_v[64:41]}, {44'h0, ev[64:41]});
    chk({pre, "R6 imm"},          {35'h0, act_v[40:8]},  {35'h0, ev[40:8]});
    chk({pre, "R10 rc"},          {67'h0, act_v[7]},     {67'h0, ev[7]});
    chk({pre, "R8 len"},          {65'h0, act_v[6:4]},   {65'h0, ev[6:4]});
    chk({pre, "R9 upd"},          {67'h0, act_v[3]},     {67'h0, ev[3]});
    chk({pre, "R11 crf"},         {65'h0, act_v[2:0]},   {65'h0, ev[2:0]});
  endtask

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R1: reset clears outputs even with a legal word present
    insn = {6'd14, 5'd3, 5'd4, 16'h1234};
    @(posedge clk); @(posedge clk); #1;
    chk("R1 reset", act_v, 68'h0);
    @(negedge clk);
    rst = 1'b0;

    for (int s = 0; s < 2; s++) begin
      for (int k = 0; k < 18; k++) begin
        for (int i = 0; i < 8; i++) begin
          logic [15:0] v;
          case (i)
            0: v = 16'h7FFF; 1: v = 16'h8000; 2: v = 16'h0000; 3: v = 16'hFFFF;
            default: v = 16'((k * 977 + i * 4099) & 16'hFFFF);
          endcase
          run_kind(k, 5'((k * 3 + i * 11) % 32), 5'((k * 5 + i * 7 + 1) % 32),
                   5'((k * 13 + i * 3 + 2) % 32), v, i[0], s[0]);
        end
      end
    end

    // R2: latency, output holds until the next edge
    apply({6'd31, 5'd1, 5'd2, 5'd3, 10'd266, 1'b0}, 1'b0);
    @(negedge clk);
    insn = 32'h0;
    swap = 1'b0;
    #1;
    chk("R2 hold", {65'h0, op_o}, {65'h0, 3'd1});
    @(posedge clk); #1;
    chk("R2 update", {65'h0, op_o}, {65'h0, 3'd0});

    // R12: primary opcode sweep
    for (int p = 0; p < 64; p++) begin
      if (!(p inside {14, 15, 24, 28, 32, 33, 34, 36, 37, 38, 40, 44})) begin
        apply({6'(p), 26'h3FF_FFFF}, 1'b0);
        chk("R12 primary", act_v, 68'h0);
      end
    end
    // R12: extended opcode sweep through the byte-reversal path
    for (int x = 0; x < 1024; x++) begin
      if (!(x inside {0, 23, 28, 151, 266, 444})) begin
        apply({6'd31, 15'h7FFF, 10'(x), 1'b1}, 1'b1);
        chk("R12 R3 extended", act_v, 68'h0);
      end
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule